// File: doc/BRIEF.md
# Cross-Domain Register Write Synchronizer

This block sits on the bus side of a chip region whose registers run from a slow low-power clock. A bus master issues a register write with an address and 32 bits of data. The block holds the write in a staging register and hands it to the slow domain with a single toggle. The slow domain then raises a one-cycle commit strobe, and the target registers take the write from it. An acknowledge toggle travels back through a two-flop synchronizer. When it arrives, the bus side clears its busy state and raises a completion flag.

Software watches the progress of a write through a status word. The word holds four bits: busy, ready for the next write, write complete and write error. Reading the status word clears the completion flag. The interrupt enable register is handled locally at bus speed and never passes through the slow path.

Each of the three reportable flags can be routed to a single interrupt line. A write issued while an earlier one is still in flight is refused and flagged as an error. An error is cleared by a status write that carries a one in the error position. That clearing write travels the slow path like any other write.

Top module: `xdom_write_sync`

## Requirements
- R1: A write to any address other than the enable register (0x18), accepted while busy is clear, sets busy on the next bus cycle and produces exactly one commit strobe in the slow domain carrying that address and data.
- R2: Busy stays set until the commit acknowledge has crossed back to the bus clock. Busy clears in the same cycle that the write-complete flag sets.
- R3: A read of the status address (0x14) returns its data on the cycle after the read request. The layout is busy at bit 10, write-next at bit 9, write-complete at bit 8 and write-error at bit 7, and all other bits are zero.
- R4: A status read clears write-complete. If a completion arrives in the same cycle as a status read, the flag ends up set, and the read returns the value it had before that cycle.
- R5: A write to the enable register takes effect on the next cycle whether or not busy is set. It produces no commit strobe, does not change busy and does not set write-complete. Reads return the enables at bits 9, 8 and 7.
- R6: A non-enable write issued while busy is set is refused. It sets write-error and leaves the staged address and data unchanged, so only the first write is committed.
- R7: A status write carrying 1 at bit 7 clears write-error when its own commit completes. A status write with 0 at bit 7 leaves write-error as it was. Both kinds of status write are committed like any other write.
- R8: Write-next reads as 1 exactly when busy is 0.
- R9: The interrupt output goes high one cycle after any flag is 1 together with its enable bit (bit 9 write-next, bit 8 write-complete, bit 7 write-error). It goes low one cycle after no enabled flag remains.
- R10: After reset, the status reads 0x200, the enables read 0, the interrupt is low and no commit strobe is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write request, one cycle |
| wr_addr | input | 8 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Registered interrupt request |
| lp_clk | input | 1 | Slow low-power clock |
| lp_rst | input | 1 | Synchronous active-high reset, slow domain |
| commit_valid | output | 1 | One slow-cycle strobe per forwarded write |
| commit_addr | output | 8 | Address of the committed write |
| commit_data | output | 32 | Data of the committed write |

## Verification
Two events can land on the same bus cycle: a status read, which clears write-complete, and the arrival of the acknowledge, which sets it. The bench provokes this by holding the read request high on every cycle while a write is in flight, so the acknowledge always meets a read. The first word that shows busy clear must also show write-complete set, and the word after it must show write-complete clear. If the clear took priority, the completion would be lost, and the first idle word would show both bits zero.

// File: rtl/xws_pkg.sv
package xws_pkg;
  // status word positions; software decodes these
  localparam int STAT_BUSY_BIT = 10;
  localparam int STAT_NEXT_BIT = 9;
  localparam int STAT_DONE_BIT = 8;
  localparam int STAT_ERR_BIT  = 7;

  // packed so the field order matches bits 9..7 of status and enable words
  typedef struct packed {
    logic next;
    logic done;
    logic err;
  } wflags_t;
endpackage

// File: rtl/xws_sync.sv
module xws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xws_lp_commit.sv
module xws_lp_commit #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_lvl,
  input  logic [ADDR_W-1:0] stage_addr,
  input  logic [DATA_W-1:0] stage_data,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              ack_tgl
);
  logic req_seen;
  logic new_req;

  assign new_req = (req_lvl != req_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen     <= 1'b0;
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
      ack_tgl      <= 1'b0;
    end else begin
      req_seen     <= req_lvl;
      commit_valid <= new_req;
      if (new_req) begin
        // staged fields have been stable for at least the sync depth
        commit_addr <= stage_addr;
        commit_data <= stage_data;
        ack_tgl     <= req_lvl;
      end
    end
  end

  // R1: one strobe per forwarded write
  assert_commit_single_R1: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> !commit_valid);
endmodule

// File: rtl/xws_bus_front.sv
module xws_bus_front
  import xws_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h14,
  parameter logic [ADDR_W-1:0] IER_ADDR  = 8'h18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic [ADDR_W-1:0] stage_addr,
  output logic [DATA_W-1:0] stage_data,
  output logic              req_tgl,
  input  logic              ack_lvl
);
  logic    busy, wcf, wef, ack_seen;
  wflags_t ier_q, flags;
  logic    ack, ier_wr, slow_wr, accept, reject, rd_stat, err_clr;
  logic [DATA_W-1:0] rd_word;

  assign ack     = (ack_lvl != ack_seen);
  assign ier_wr  = wr_en && (wr_addr == IER_ADDR);
  assign slow_wr = wr_en && (wr_addr != IER_ADDR);
  assign accept  = slow_wr && !busy;
  assign reject  = slow_wr && busy;
  assign rd_stat = rd_en && (rd_addr == STAT_ADDR);
  // staged write is an error-clear request
  assign err_clr = (stage_addr == STAT_ADDR) && stage_data[STAT_ERR_BIT];

  always_comb begin
    flags.next = !busy;
    flags.done = wcf;
    flags.err  = wef;
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == STAT_ADDR) begin
      rd_word[STAT_BUSY_BIT]                = busy;
      rd_word[STAT_NEXT_BIT:STAT_ERR_BIT]   = flags;
    end else if (rd_addr == IER_ADDR) begin
      rd_word[STAT_NEXT_BIT:STAT_ERR_BIT]   = ier_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      wcf        <= 1'b0;
      wef        <= 1'b0;
      ack_seen   <= 1'b0;
      req_tgl    <= 1'b0;
      ier_q      <= '0;
      stage_addr <= '0;
      stage_data <= '0;
      rd_data    <= '0;
      irq        <= 1'b0;
    end else begin
      ack_seen <= ack_lvl;
      irq      <= |(flags & ier_q);

      if (ier_wr) ier_q <= wr_data[STAT_NEXT_BIT:STAT_ERR_BIT];

      if (accept) begin
        stage_addr <= wr_addr;
        stage_data <= wr_data;
        req_tgl    <= !req_tgl;
        busy       <= 1'b1;
      end else if (ack) begin
        busy <= 1'b0;
      end

      // completion set wins over read clear
      if (ack)          wcf <= 1'b1;
      else if (rd_stat) wcf <= 1'b0;

      // refused write set wins over clear
      if (reject)              wef <= 1'b1;
      else if (ack && err_clr) wef <= 1'b0;

      if (rd_en) rd_data <= rd_word;
    end
  end

  assert_busy_set_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  assert_busy_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack) |=> busy);

  assert_done_on_ack_R2: assert property (@(posedge clk) disable iff (rst)
    ack |=> (wcf && !busy));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !ack) |=> !wcf);

  assert_ier_local_R5: assert property (@(posedge clk) disable iff (rst)
    (ier_wr && !ack && !busy) |=> (!busy && !$rose(wcf)));

  assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    reject |=> (wef && $stable(stage_data) && $stable(stage_addr)));

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & ier_q)) |=> !irq);
endmodule

// File: rtl/xdom_write_sync.sv
module xdom_write_sync #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 32,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h14,
  parameter logic [ADDR_W-1:0] IER_ADDR    = 8'h18
) (
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  input  logic              lp_clk,
  input  logic              lp_rst,
  output logic              commit_valid,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  logic              req_tgl, req_lvl, ack_tgl, ack_lvl;
  logic [ADDR_W-1:0] stage_addr;
  logic [DATA_W-1:0] stage_data;

  xws_bus_front #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STAT_ADDR(STAT_ADDR), .IER_ADDR(IER_ADDR)
  ) u_front (
    .clk(bus_clk), .rst(bus_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq),
    .stage_addr(stage_addr), .stage_data(stage_data),
    .req_tgl(req_tgl), .ack_lvl(ack_lvl)
  );

  xws_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(lp_clk), .rst(lp_rst), .d(req_tgl), .q(req_lvl)
  );

  xws_lp_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_commit (
    .clk(lp_clk), .rst(lp_rst),
    .req_lvl(req_lvl),
    .stage_addr(stage_addr), .stage_data(stage_data),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .ack_tgl(ack_tgl)
  );

  xws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_lvl)
  );
endmodule

// File: tb/xdom_write_sync_test.sv
module xdom_write_sync_test;
  localparam logic [7:0] STAT = 8'h14;
  localparam logic [7:0] IER  = 8'h18;

  logic        bus_clk = 1'b0, lp_clk = 1'b0;
  logic        bus_rst = 1'b1, lp_rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, commit_valid;
  logic [7:0]  commit_addr;
  logic [31:0] commit_data;

  int checks = 0, failures = 0, n_commit = 0;
  logic [7:0]  last_caddr;
  logic [31:0] last_cdata;
  logic        done = 1'b0;

  always #2  bus_clk = ~bus_clk;
  always #13 lp_clk  = ~lp_clk;

  xdom_write_sync uut (
    .bus_clk(bus_clk), .bus_rst(bus_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq),
    .lp_clk(lp_clk), .lp_rst(lp_rst),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  always @(negedge lp_clk) begin
    if (commit_valid) begin
      n_commit++;
      last_caddr = commit_addr;
      last_cdata = commit_data;
    end
  end

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge bus_clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // reads status on every cycle until busy drops; returns first word,
  // first idle word and the word after it
  task automatic stream_idle(output logic [31:0] first, output logic [31:0] idle,
                             output logic [31:0] after);
    rd_en = 1'b1; rd_addr = STAT;
    @(negedge bus_clk);
    first = rd_data;
    idle  = rd_data;
    for (int i = 0; i < 400; i++) begin
      if (!idle[10]) break;
      @(negedge bus_clk);
      idle = rd_data;
    end
    @(negedge bus_clk);
    after = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge bus_clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check_eq("R10 irq after reset", {31'd0, irq}, 32'd0);
    bus_read(STAT, v);
    check_eq("R10 R3 status after reset", v, 32'h200);
    bus_read(IER, v);
    check_eq("R10 enables after reset", v, 32'h0);
    check_eq("R10 no commit", n_commit, 0);
  endtask

  task automatic t_basic;
    logic [31:0] f, i, a;
    int c0 = n_commit;
    bus_write(8'h10, 32'hA5C3_0F1E);
    stream_idle(f, i, a);
    check_eq("R1 R8 busy set, next clear", f, 32'h400);
    check_eq("R2 R4 completion seen in read collision", i, 32'h300);
    check_eq("R4 read clears complete", a, 32'h200);
    idle_cycles(4);
    check_eq("R1 one commit", n_commit, c0 + 1);
    check_eq("R1 commit addr", {24'd0, last_caddr}, 32'h10);
    check_eq("R1 commit data", last_cdata, 32'hA5C3_0F1E);
  endtask

  task automatic t_ier;
    logic [31:0] v, f, i, a;
    int c0 = n_commit;
    bus_write(IER, 32'hFFFF_FD7F);
    bus_read(IER, v);
    check_eq("R5 enable readback", v, 32'h100);
    bus_read(STAT, v);
    check_eq("R5 no busy/complete from enable write", v, 32'h200);
    idle_cycles(40);
    check_eq("R5 no commit from enable write", n_commit, c0);
    bus_write(8'h30, 32'h1234_5678);
    bus_write(IER, 32'h0);
    stream_idle(f, i, a);
    check_eq("R5 enable write while busy not refused", i, 32'h300);
    bus_read(IER, v);
    check_eq("R5 enable write while busy applied", v, 32'h0);
    check_eq("R5 only data write committed", n_commit, c0 + 1);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    int seen = 0;
    bus_write(IER, 32'h100);
    idle_cycles(2);
    check_eq("R9 no irq without flag", {31'd0, irq}, 32'd0);
    bus_write(8'h40, 32'hCAFE_0001);
    for (int k = 0; k < 400; k++) begin
      @(negedge bus_clk);
      if (irq) begin seen = 1; break; end
    end
    check_eq("R9 irq on complete", seen, 1);
    bus_read(STAT, v);
    check_eq("R9 status at irq", v, 32'h300);
    @(negedge bus_clk);
    check_eq("R9 irq falls after read", {31'd0, irq}, 32'd0);
    bus_write(IER, 32'h200);
    @(negedge bus_clk);
    check_eq("R9 irq on write-next", {31'd0, irq}, 32'd1);
    bus_write(IER, 32'h0);
    @(negedge bus_clk);
    check_eq("R9 irq off", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reject;
    logic [31:0] f, i, a;
    int c0 = n_commit;
    bus_write(8'h20, 32'hD1D1_D1D1);
    bus_write(8'h24, 32'hD2D2_D2D2);
    stream_idle(f, i, a);
    check_eq("R6 error set by refused write", i, 32'h380);
    idle_cycles(4);
    check_eq("R6 single commit", n_commit, c0 + 1);
    check_eq("R6 first addr kept", {24'd0, last_caddr}, 32'h20);
    check_eq("R6 first data kept", last_cdata, 32'hD1D1_D1D1);
  endtask

  task automatic t_clear_err;
    logic [31:0] f, i, a;
    int c0 = n_commit;
    bus_write(STAT, 32'h0000_0000);
    stream_idle(f, i, a);
    check_eq("R7 zero bit7 keeps error", i, 32'h380);
    check_eq("R7 R4 error stays after read", a, 32'h280);
    bus_write(STAT, 32'h0000_0080);
    stream_idle(f, i, a);
    check_eq("R7 bit7 clears error", i, 32'h300);
    idle_cycles(4);
    check_eq("R7 status writes committed", n_commit, c0 + 2);
    check_eq("R7 commit addr", {24'd0, last_caddr}, {24'd0, STAT});
  endtask

  initial begin
    idle_cycles(20);
    bus_rst = 1'b0; lp_rst = 1'b0;
    idle_cycles(4);
    t_reset();
    t_basic();
    t_ier();
    t_irq();
    t_reject();
    t_clear_err();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge bus_clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule